// File: doc/BRIEF.md
# Colour Standard Selector

This block picks the colour standard a multi-standard receiver should decode. It then drives a three-bit switch code that steers the chroma and filter paths. A separate select line chooses between the 4.43 MHz family (PAL or SECAM) and the 3.58 MHz path. A two-bit status gives the committed standard for on-screen display.

A stored user setting chooses either automatic detection or one fixed standard. In automatic mode the standard comes from an 8-bit ADC sample of the ident voltage, sorted into three bands. A special rule covers monochrome 60 Hz broadcasts received through the tuner: these are forced to NTSC. The block evaluates once per `tick` pulse. A new decision reaches the outputs only after it has been identical for a programmable number of consecutive ticks (four by default), so a noisy ident reading cannot make the filters chatter.

Top module: `colsel_top`

## Requirements
- R1: `sys_code` (bit 2 down to bit 0) is 3'b110 for automatic/4.43 detect, 3'b100 for PAL 4.43, 3'b101 for SECAM and 3'b010 for NTSC; no other value ever appears out of reset.
- R2: With the default 5 V full scale, `ident_adc` below 92 is read as no sync (4.43 family), 92 to 219 as a 3.58 MHz signal, and 220 or above as a 4.43 MHz signal.
- R3: While `rst` is high at a clock edge, the outputs become `sys_code`=3'b110, `pal_secam_n`=0 and `std_status`=0.
- R4: `pal_secam_n` is 0 whenever the committed standard is automatic/4.43, PAL or SECAM, and 1 when it is NTSC.
- R5: With `user_sel`=0 (automatic) and no monochrome override, a 3.58 MHz ident band resolves to NTSC, and the no-sync and 4.43 MHz bands resolve to the automatic code.
- R6: With `user_sel`=1 (PAL), 2 (SECAM) or 3 (NTSC), that standard is resolved and `ident_adc` has no effect on the outputs.
- R7: When `chroma_ok`=0 (monochrome), `field_60`=1 (60 Hz), `tv_mode`=1 (tuner) and `user_sel` is 0 or 3, the resolved standard is NTSC regardless of the ident band.
- R8: If any one of the R7 conditions is missing (`field_60`=0, `tv_mode`=0, or `user_sel` of 1 or 2), `chroma_ok`=0 changes nothing and R5/R6 apply.
- R9: Outputs change only at a clock edge with `tick`=1. At that edge the resolved standard must have been the same on this tick and the three ticks before it. A run of three or fewer leaves the outputs as they were.
- R10: `std_status` is 0 for automatic, 1 for PAL, 2 for SECAM and 3 for NTSC, and it updates at the same edge as `sys_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle evaluation strobe |
| user_sel | input | 2 | Stored standard setting: 0 auto, 1 PAL, 2 SECAM, 3 NTSC |
| chroma_ok | input | 1 | 1 when a colour burst is present, 0 for monochrome |
| field_60 | input | 1 | 1 for a 60 Hz field rate, 0 for 50 Hz |
| tv_mode | input | 1 | 1 for tuner reception, 0 for an external AV source |
| ident_adc | input | ADC_W (8) | ADC sample of the ident voltage |
| sys_code | output | 3 | Registered colour system switch code |
| pal_secam_n | output | 1 | Low selects the 4.43 MHz PAL/SECAM path |
| std_status | output | 2 | Committed standard for display |

## Verification
The sweep covers every combination of setting, chroma, field rate and source mode. For each one it drives ADC values that sit on both sides of each band threshold, so a threshold off by one count would mis-sort 91/92 or 219/220. Monochrome cases with exactly one override condition missing would expose a rule that checks too few conditions. Ident changes under a fixed setting would expose a fixed standard that leaks ident. Runs of three equal ticks broken by a different value would expose a filter that commits early or fails to restart its count. Input changes held between ticks would expose outputs that follow the inputs without waiting for a tick.

// File: rtl/colsel_pkg.sv
package colsel_pkg;

  typedef enum logic [1:0] {
    STD_AUTO  = 2'd0,
    STD_PAL   = 2'd1,
    STD_SECAM = 2'd2,
    STD_NTSC  = 2'd3
  } std_e;

  typedef enum logic [1:0] {
    BAND_NOSYNC = 2'd0,
    BAND_358    = 2'd1,
    BAND_443    = 2'd2
  } band_e;

  localparam logic [2:0] CODE_AUTO  = 3'b110;
  localparam logic [2:0] CODE_PAL   = 3'b100;
  localparam logic [2:0] CODE_SECAM = 3'b101;
  localparam logic [2:0] CODE_NTSC  = 3'b010;

  function automatic logic [2:0] std_code(std_e s);
    case (s)
      STD_PAL:   return CODE_PAL;
      STD_SECAM: return CODE_SECAM;
      STD_NTSC:  return CODE_NTSC;
      default:   return CODE_AUTO;
    endcase
  endfunction

  function automatic logic std_is_443(std_e s);
    return (s != STD_NTSC);
  endfunction

endpackage

// File: rtl/colsel_ident_decode.sv
module colsel_ident_decode
  import colsel_pkg::*;
#(
  parameter int ADC_W   = 8,
  parameter int FULL_MV = 5000,
  parameter int LO_MV   = 1800,
  parameter int HI_MV   = 4300
) (
  input  logic [ADC_W-1:0] adc,
  output band_e            band
);
  localparam int TH_LO = (LO_MV * (2 ** ADC_W)) / FULL_MV;
  localparam int TH_HI = (HI_MV * (2 ** ADC_W)) / FULL_MV;
  localparam logic [ADC_W:0] TH_LO_V = (ADC_W+1)'(TH_LO);
  localparam logic [ADC_W:0] TH_HI_V = (ADC_W+1)'(TH_HI);

  logic [ADC_W:0] adc_x;
  assign adc_x = {1'b0, adc};

  always_comb begin
    if (adc_x < TH_LO_V)      band = BAND_NOSYNC;
    else if (adc_x < TH_HI_V) band = BAND_358;
    else                      band = BAND_443;
  end
endmodule

// File: rtl/colsel_rule.sv
module colsel_rule
  import colsel_pkg::*;
(
  input  std_e  user,
  input  logic  chroma_ok,
  input  logic  field_60,
  input  logic  tv_mode,
  input  band_e band,
  output std_e  res
);
  logic mono_force;

  assign mono_force = !chroma_ok && field_60 && tv_mode &&
                      ((user == STD_AUTO) || (user == STD_NTSC));

  always_comb begin
    if (mono_force)
      res = STD_NTSC;
    else if (user != STD_AUTO)
      res = user;
    else if (band == BAND_358)
      res = STD_NTSC;
    else
      res = STD_AUTO;
  end
endmodule

// File: rtl/colsel_stable.sv
module colsel_stable #(
  parameter int              W       = 2,
  parameter int              STABLE  = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] din,
  output logic         commit_en
);
  localparam int CW = $clog2(STABLE + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(STABLE);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [W-1:0]  cand;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    if (din != cand)        cnt_nx = CNT_ONE;
    else if (cnt == CNT_MAX) cnt_nx = cnt;
    else                    cnt_nx = cnt + CNT_ONE;
    commit_en = tick && (cnt_nx == CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand <= RST_VAL;
      cnt  <= '0;
    end else if (tick) begin
      cand <= din;
      cnt  <= cnt_nx;
    end
  end
endmodule

// File: rtl/colsel_top.sv
module colsel_top
  import colsel_pkg::*;
#(
  parameter int ADC_W        = 8,
  parameter int FULL_MV      = 5000,
  parameter int LO_MV        = 1800,
  parameter int HI_MV        = 4300,
  parameter int STABLE_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       user_sel,
  input  logic             chroma_ok,
  input  logic             field_60,
  input  logic             tv_mode,
  input  logic [ADC_W-1:0] ident_adc,
  output logic [2:0]       sys_code,
  output logic             pal_secam_n,
  output logic [1:0]       std_status
);
  band_e band;
  std_e  res;
  logic  commit_en;

  colsel_ident_decode #(
    .ADC_W(ADC_W), .FULL_MV(FULL_MV), .LO_MV(LO_MV), .HI_MV(HI_MV)
  ) u_decode (
    .adc  (ident_adc),
    .band (band)
  );

  colsel_rule u_rule (
    .user      (std_e'(user_sel)),
    .chroma_ok (chroma_ok),
    .field_60  (field_60),
    .tv_mode   (tv_mode),
    .band      (band),
    .res       (res)
  );

  generate
    if (STABLE_TICKS > 1) begin : g_filter
      colsel_stable #(
        .W(2), .STABLE(STABLE_TICKS), .RST_VAL(2'(STD_AUTO))
      ) u_stable (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .din       (2'(res)),
        .commit_en (commit_en)
      );
    end else begin : g_direct
      assign commit_en = tick;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_code    <= CODE_AUTO;
      pal_secam_n <= 1'b0;
      std_status  <= 2'(STD_AUTO);
    end else if (commit_en) begin
      sys_code    <= std_code(res);
      pal_secam_n <= !std_is_443(res);
      std_status  <= 2'(res);
    end
  end
endmodule

// File: rtl/colsel_sva.sv
module colsel_sva (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [2:0] sys_code,
  input logic       pal_secam_n,
  input logic [1:0] std_status
);
  assert_reset_state_R3: assert property (@(posedge clk)
    rst |=> (sys_code == 3'b110 && !pal_secam_n && std_status == 2'd0));

  assert_legal_code_R1: assert property (@(posedge clk) disable iff (rst)
    (sys_code == 3'b110 || sys_code == 3'b100 ||
     sys_code == 3'b101 || sys_code == 3'b010));

  assert_select_follows_code_R4: assert property (@(posedge clk) disable iff (rst)
    pal_secam_n == (sys_code == 3'b010));

  assert_status_matches_code_R10: assert property (@(posedge clk) disable iff (rst)
    ((std_status == 2'd3) == (sys_code == 3'b010)) &&
    ((std_status == 2'd2) == (sys_code == 3'b101)) &&
    ((std_status == 2'd1) == (sys_code == 3'b100)));

  assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(sys_code) && $stable(std_status) && $stable(pal_secam_n)));
endmodule

bind colsel_top colsel_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .sys_code    (sys_code),
  .pal_secam_n (pal_secam_n),
  .std_status  (std_status)
);

// File: tb/colsel_top_tb_top.sv
module colsel_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] user_sel = 2'd0;
  logic       chroma_ok = 1'b1;
  logic       field_60 = 1'b0;
  logic       tv_mode = 1'b1;
  logic [7:0] ident_adc = 8'd255;
  logic [2:0] sys_code;
  logic       pal_secam_n;
  logic [1:0] std_status;

  int n_run = 0;
  int n_fail = 0;
  int m_last = 0;
  int m_run = 0;
  int m_comm = 0;

  always #5 clk = ~clk;

  colsel_top dut_i (
    .clk(clk), .rst(rst), .tick(tick), .user_sel(user_sel),
    .chroma_ok(chroma_ok), .field_60(field_60), .tv_mode(tv_mode),
    .ident_adc(ident_adc), .sys_code(sys_code),
    .pal_secam_n(pal_secam_n), .std_status(std_status)
  );

  function automatic int resolve(int u, int c, int f, int t, int a);
    if (c == 0 && f == 1 && t == 1 && (u == 0 || u == 3)) return 3;
    if (u != 0) return u;
    if (a >= 92 && a < 220) return 3;
    return 0;
  endfunction

  function automatic logic [2:0] code_of(int s);
    case (s)
      1: return 3'b100;
      2: return 3'b101;
      3: return 3'b010;
      default: return 3'b110;
    endcase
  endfunction

  task automatic chk(string tag);
    n_run++;
    if (sys_code !== code_of(m_comm)) begin
      n_fail++;
      $display("FAIL %s R1 sys_code actual=%b expected=%b", tag, sys_code, code_of(m_comm));
    end
    n_run++;
    if (pal_secam_n !== (m_comm == 3)) begin
      n_fail++;
      $display("FAIL R4 (%s) pal_secam_n actual=%b expected=%b", tag, pal_secam_n, (m_comm == 3));
    end
    n_run++;
    if (std_status !== 2'(m_comm)) begin
      n_fail++;
      $display("FAIL R10 (%s) std_status actual=%0d expected=%0d", tag, std_status, m_comm);
    end
  endtask

  task automatic set_in(int u, int c, int f, int t, int a);
    @(negedge clk);
    user_sel = 2'(u); chroma_ok = 1'(c); field_60 = 1'(f);
    tv_mode = 1'(t); ident_adc = 8'(a);
  endtask

  task automatic do_tick(string tag);
    int r;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    r = resolve(user_sel, chroma_ok, field_60, tv_mode, ident_adc);
    if (r == m_last) begin
      if (m_run < 4) m_run++;
    end else begin
      m_last = r;
      m_run = 1;
    end
    if (m_run >= 4) m_comm = r;
    chk(tag);
  endtask

  task automatic idle_chk(int cycles);
    repeat (cycles) @(negedge clk);
    chk("R9 idle");
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int adcs[7] = '{0, 91, 92, 150, 219, 220, 255};
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R3 reset");

    // R9: chatter, runs of three never commit
    set_in(0, 1, 0, 1, 150);
    repeat (3) do_tick("R9 short run");
    set_in(0, 1, 0, 1, 255);
    do_tick("R9 interrupted");
    set_in(0, 1, 0, 1, 150);
    repeat (3) do_tick("R9 short run");
    do_tick("R9 fourth tick commits");
    set_in(0, 1, 0, 1, 20);
    idle_chk(5);

    for (int u = 0; u < 4; u++)
      for (int c = 0; c < 2; c++)
        for (int f = 0; f < 2; f++)
          for (int t = 0; t < 2; t++)
            for (int i = 0; i < 7; i++) begin
              set_in(u, c, f, t, adcs[i]);
              idle_chk(2);
              if (c == 0 && f == 1 && t == 1 && (u == 0 || u == 3)) tag = "R7 mono force";
              else if (c == 0) tag = "R8 mono no force";
              else if (u == 0 && (i == 1 || i == 2 || i == 4 || i == 5)) tag = "R2 band edge";
              else if (u == 0) tag = "R5 auto";
              else tag = "R6 fixed";
              repeat (5) do_tick(tag);
            end

    // R6: ident sweep under a fixed setting must not move the output
    set_in(2, 1, 0, 1, 255);
    repeat (4) do_tick("R6 fixed secam");
    for (int a = 0; a < 256; a += 17) begin
      set_in(2, 1, 0, 1, a);
      do_tick("R6 ident ignored");
    end

    // R3 again: reset from a non-auto state
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    m_last = 0; m_run = 0; m_comm = 0;
    chk("R3 reset after run");
    finish_up();
  end
endmodule